// File: doc/BRIEF.md
# Synchronous Processor Register Port

This block is a chip-select driven slave port through which an external processor reads and writes a small bank of control and status registers. All port signals are sampled on rising edges of one interface clock. A read drives a registered data word, with an output-enable that stands in for the tri-state driver. A write is captured once per select assertion. The port also collects event pulses, counter increments and a live status word from the rest of the chip. It keeps an event register with an error flag and raises an interrupt when an enabled event is pending.

The access protocol is a plain select/strobe handshake, not a valid/ready stream. The processor paces every access by how long it holds select, and the port never stalls it. A read lasts at least two clocks. It keeps the driver on until select has been seen low on two consecutive edges. Write data must be valid on the edge that follows the one where select was first seen.

Top module: `cpu_reg_port`

## Requirements
- R1: Address and direction are captured on the edge where select is first seen high in idle. Later changes to either input during the same access have no effect.
- R2: With direction high (read), `rd_oe_o` rises after the capturing edge. `rdata_o` holds the addressed register from the next edge onward. Register map: 0 event, 1 event mask, 2/3/4 violation/idle/link counters, 5 status input, 6 control, 7..10 special load registers (transmit vector, vector length, timer A, timer B). Addresses 11..15 read zero.
- R3: If select is low on the second edge, the driver is on for exactly two clocks.
- R4: Each edge that samples select high extends the read. The driver turns off after the second consecutive edge that samples select low.
- R5: Reading the event register (0) or any counter (2, 3, 4) returns its value and clears it. Reading any other address changes nothing.
- R6: With direction low (write), the data on `wdata_i` is captured on the second edge of the access. The driver stays off for the whole write.
- R7: Each select assertion makes at most one write. Data changes while select stays high are ignored. Select must drop before a new access starts.
- R8: A write to a read-only or unmapped address (0, 2, 3, 4, 5, 11..15) leaves every register unchanged and sets event bit 7, the write-error flag.
- R9: While `lock_i` is high, a write to addresses 7..10 is dropped and sets event bit 7. While it is low, the write is accepted.
- R10: `irq_o` is high exactly when some event bit is set whose mask bit is also set. Event bits 6..0 are set by `evt_i` bits 6..0.
- R11: An event or counter increment that lands on the same edge as the clear-on-read of its register is kept after the clear.
- R12: The counters saturate at all-ones instead of wrapping.
- R13: Synchronous active-high reset leaves the port idle, the driver off, `irq_o` low and every register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select |
| rd_wr_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | 4 | Register address |
| wdata_i | input | DW | Write data |
| lock_i | input | 1 | Blocks writes to the special load registers |
| evt_i | input | EVW | Event pulses, sticky into the event register |
| cnt_inc_i | input | 3 | Increments for the violation, idle and link counters |
| stat_i | input | DW | Live status word read at address 5 |
| rdata_o | output | DW | Read data |
| rd_oe_o | output | 1 | Read data driver enable |
| irq_o | output | 1 | Interrupt, masked event pending |

## Verification
The bench builds the port with its default widths: 8-bit data and seven event inputs. With these widths the write-error flag sits directly above the event bits, so one masked read of the event register shows both at once. The 8-bit counters saturate at 255, which a few hundred increment cycles reach, so the hold-at-maximum case is driven rather than only reasoned about. Select hold lengths from zero to several cycles place both the minimum and the stretched read windows and the repeated-write window at their exact edges.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int RP_AW    = 4;
  localparam int NUM_CTR  = 3;
  localparam int NUM_SPEC = 4;

  localparam logic [RP_AW-1:0] A_EVT   = 4'd0;
  localparam logic [RP_AW-1:0] A_MASK  = 4'd1;
  localparam logic [RP_AW-1:0] A_CTR0  = 4'd2;
  localparam logic [RP_AW-1:0] A_STAT  = 4'd5;
  localparam logic [RP_AW-1:0] A_CTRL  = 4'd6;
  localparam logic [RP_AW-1:0] A_SPEC0 = 4'd7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LEAD,
    S_RD_HOLD,
    S_WR_LEAD,
    S_WR_WAIT
  } seq_st_e;

  function automatic logic [RP_AW-1:0] ctr_addr(input int k);
    return RP_AW'(int'(A_CTR0) + k);
  endfunction

  function automatic logic [RP_AW-1:0] spec_addr(input int k);
    return RP_AW'(int'(A_SPEC0) + k);
  endfunction
endpackage

// File: rtl/rp_sat_ctr.sv
module rp_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  // clear first, then add, so a coincident increment survives
  always_comb begin
    nxt = clr_i ? '0 : q_o;
    if (inc_i && nxt != '1) nxt = nxt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt;
  end
endmodule

// File: rtl/rp_seq.sv
module rp_seq
  import rp_pkg::*;
#(
  parameter int AW = RP_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          rd_wr_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          drive_o
);
  seq_st_e st;
  logic    low_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      low_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (sel_i) begin
          addr_q <= addr_i;
          st     <= rd_wr_i ? S_RD_LEAD : S_WR_LEAD;
        end
        S_RD_LEAD: begin
          st       <= S_RD_HOLD;
          low_seen <= !sel_i;
        end
        S_RD_HOLD: begin
          if (sel_i)         low_seen <= 1'b0;
          else if (low_seen) st <= S_IDLE;
          else               low_seen <= 1'b1;
        end
        S_WR_LEAD: st <= sel_i ? S_WR_WAIT : S_IDLE;
        S_WR_WAIT: if (!sel_i) st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign rd_stb  = (st == S_RD_LEAD);
  assign wr_stb  = (st == S_WR_LEAD);
  assign drive_o = (st == S_RD_LEAD) || (st == S_RD_HOLD);
endmodule

// File: rtl/rp_regbank.sv
module rp_regbank
  import rp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int EVW = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RP_AW-1:0]             addr_i,
  input  logic                         rd_stb,
  input  logic                         wr_stb,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         lock_i,
  input  logic [EVW-1:0]               evt_i,
  input  logic [DW-1:0]                stat_i,
  input  logic [NUM_CTR-1:0][DW-1:0]   ctr_i,
  output logic [NUM_CTR-1:0]           ctr_clr_o,
  output logic [DW-1:0]                rdata_o,
  output logic                         irq_o
);
  localparam int ERR_BIT = DW - 1;

  logic [DW-1:0]               evt_q, mask_q, ctrl_q, rd_val, evt_set;
  logic [NUM_SPEC-1:0][DW-1:0] spec_q;
  logic                        spec_hit, wr_ok, wr_bad, evt_clr;

  always_comb begin
    spec_hit = 1'b0;
    for (int k = 0; k < NUM_SPEC; k++)
      if (addr_i == spec_addr(k)) spec_hit = 1'b1;
  end

  assign wr_ok   = wr_stb && ((addr_i == A_MASK) || (addr_i == A_CTRL) ||
                              (spec_hit && !lock_i));
  assign wr_bad  = wr_stb && !wr_ok;
  assign evt_clr = rd_stb && (addr_i == A_EVT);

  always_comb begin
    evt_set              = '0;
    evt_set[EVW-1:0]     = evt_i;
    evt_set[ERR_BIT]     = wr_bad;
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_clr
    assign ctr_clr_o[g] = rd_stb && (addr_i == ctr_addr(g));
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == A_EVT)  rd_val = evt_q;
    if (addr_i == A_MASK) rd_val = mask_q;
    if (addr_i == A_STAT) rd_val = stat_i;
    if (addr_i == A_CTRL) rd_val = ctrl_q;
    for (int k = 0; k < NUM_CTR; k++)
      if (addr_i == ctr_addr(k)) rd_val = ctr_i[k];
    for (int k = 0; k < NUM_SPEC; k++)
      if (addr_i == spec_addr(k)) rd_val = spec_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q   <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
      spec_q  <= '0;
      rdata_o <= '0;
    end else begin
      evt_q <= (evt_clr ? '0 : evt_q) | evt_set;
      if (rd_stb) rdata_o <= rd_val;
      if (wr_ok) begin
        if (addr_i == A_MASK) mask_q <= wdata_i;
        if (addr_i == A_CTRL) ctrl_q <= wdata_i;
        for (int k = 0; k < NUM_SPEC; k++)
          if (addr_i == spec_addr(k)) spec_q[k] <= wdata_i;
      end
    end
  end

  assign irq_o = |(evt_q & mask_q);
endmodule

// File: rtl/cpu_reg_port.sv
module cpu_reg_port
  import rp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int EVW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               rd_wr_i,
  input  logic [RP_AW-1:0]   addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               lock_i,
  input  logic [EVW-1:0]     evt_i,
  input  logic [NUM_CTR-1:0] cnt_inc_i,
  input  logic [DW-1:0]      stat_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rd_oe_o,
  output logic               irq_o
);
  logic [RP_AW-1:0]           addr_q;
  logic                       rd_stb, wr_stb;
  logic [NUM_CTR-1:0]         ctr_clr;
  logic [NUM_CTR-1:0][DW-1:0] ctr_q;

  rp_seq #(.AW(RP_AW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .rd_wr_i (rd_wr_i),
    .addr_i  (addr_i),
    .addr_q  (addr_q),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .drive_o (rd_oe_o)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    rp_sat_ctr #(.W(DW)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .inc_i (cnt_inc_i[g]),
      .clr_i (ctr_clr[g]),
      .q_o   (ctr_q[g])
    );
  end

  rp_regbank #(.DW(DW), .EVW(EVW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_q),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wdata_i   (wdata_i),
    .lock_i    (lock_i),
    .evt_i     (evt_i),
    .stat_i    (stat_i),
    .ctr_i     (ctr_q),
    .ctr_clr_o (ctr_clr),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/rp_port_chk.sv
module rp_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_i,
  input logic         rd_wr_i,
  input logic         rd_oe_o,
  input logic         wr_stb,
  input logic [W-1:0] ctr0_q,
  input logic         ctr0_clr
);
  assert_oe_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_oe_o) |-> ($past(sel_i) && $past(rd_wr_i)));

  assert_oe_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_oe_o) |-> (!$past(sel_i) && !$past(sel_i, 2)));

  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_no_drive_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !rd_oe_o);

  assert_ctr_hold_max_R12: assert property (@(posedge clk) disable iff (rst)
    (ctr0_q == '1 && !ctr0_clr) |=> (ctr0_q == '1));

  assert_ctr_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    ctr0_clr |=> (ctr0_q <= W'(1)));
endmodule

bind cpu_reg_port rp_port_chk #(.W(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_i    (sel_i),
  .rd_wr_i  (rd_wr_i),
  .rd_oe_o  (rd_oe_o),
  .wr_stb   (wr_stb),
  .ctr0_q   (ctr_q[0]),
  .ctr0_clr (ctr_clr[0])
);

// File: tb/cpu_reg_port_tb_top.sv
`timescale 1ns/1ps
module cpu_reg_port_tb_top;
  localparam int DW = 8, EVW = 7, NC = 3, NS = 4;

  logic           clk = 1'b0, rst = 1'b1, sel = 1'b0, rw = 1'b0, lock = 1'b0;
  logic [3:0]     addr = '0;
  logic [DW-1:0]  wdata = '0, stat = '0;
  logic [EVW-1:0] evt = '0;
  logic [NC-1:0]  inc = '0;
  logic [DW-1:0]  rdata;
  logic           rd_oe, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] evt_m, mask_m, ctrl_m;
  logic [DW-1:0] ctr_m  [NC];
  logic [DW-1:0] spec_m [NS];

  always #2.5 clk = ~clk;

  cpu_reg_port #(.DW(DW), .EVW(EVW)) dut_i (
    .clk(clk), .rst(rst), .sel_i(sel), .rd_wr_i(rw), .addr_i(addr),
    .wdata_i(wdata), .lock_i(lock), .evt_i(evt), .cnt_inc_i(inc),
    .stat_i(stat), .rdata_o(rdata), .rd_oe_o(rd_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] v, input int n);
    if (int'(v) + n > (1 << DW) - 1) return '1;
    return DW'(int'(v) + n);
  endfunction

  function automatic logic [DW-1:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return evt_m;
      4'd1: return mask_m;
      4'd2, 4'd3, 4'd4: return ctr_m[a - 2];
      4'd5: return stat;
      4'd6: return ctrl_m;
      4'd7, 4'd8, 4'd9, 4'd10: return spec_m[a - 7];
      default: return '0;
    endcase
  endfunction

  task automatic chk_irq();
    chk("R10 irq", irq, |(evt_m & mask_m));
  endtask

  task automatic do_read(input logic [3:0] a, input int h, input logic [EVW-1:0] cev,
                         input logic [NC-1:0] cinc, output logic [DW-1:0] got);
    logic [DW-1:0] exp;
    int oe_bad = 0;
    @(negedge clk);
    sel = 1'b1; rw = 1'b1; addr = a;
    exp = mread(a);
    got = '0;
    for (int i = 0; i <= h + 2; i++) begin
      @(negedge clk);
      if (i == 0) begin addr = ~a; rw = 1'b0; evt = cev; inc = cinc; end
      if (i == 1) begin got = rdata; evt = '0; inc = '0; end
      if (i == h) sel = 1'b0;
      if (rd_oe !== (i <= h + 1)) oe_bad++;
    end
    chk(h == 0 ? "R3 read window" : "R4 stretched window", oe_bad, 0);
    chk((a == 0 || (a >= 2 && a <= 4)) ? "R5 read value" : "R2 read value", got, exp);
    if (a == 0) evt_m = '0;
    if (a >= 2 && a <= 4) ctr_m[a - 2] = '0;
    evt_m = evt_m | DW'(cev);
    for (int k = 0; k < NC; k++) if (cinc[k]) ctr_m[k] = sat_add(ctr_m[k], 1);
    chk_irq();
  endtask

  task automatic do_write(input logic [3:0] a, input logic [DW-1:0] d, input int h);
    int oe_bad = 0;
    @(negedge clk);
    sel = 1'b1; rw = 1'b0; addr = a; wdata = ~d;
    for (int i = 0; i <= h + 1; i++) begin
      @(negedge clk);
      if (i == 0) begin wdata = d; addr = a ^ 4'h1; rw = 1'b1; end
      if (i == 1) wdata = d ^ 8'hA5;
      if (i == h) sel = 1'b0;
      if (rd_oe !== 1'b0) oe_bad++;
    end
    chk("R6 no drive on write", oe_bad, 0);
    if (a == 1) mask_m = d;
    else if (a == 6) ctrl_m = d;
    else if (a >= 7 && a <= 10 && !lock) spec_m[a - 7] = d;
    else evt_m[DW-1] = 1'b1;
    chk_irq();
  endtask

  task automatic pulse_evt(input logic [EVW-1:0] b);
    @(negedge clk); evt = b;
    @(negedge clk); evt = '0;
    evt_m = evt_m | DW'(b);
  endtask

  task automatic pulse_inc(input logic [NC-1:0] b, input int n);
    @(negedge clk); inc = b;
    repeat (n) @(negedge clk);
    inc = '0;
    for (int k = 0; k < NC; k++) if (b[k]) ctr_m[k] = sat_add(ctr_m[k], n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    int r;
    void'($urandom(32'h5EED_1234));
    evt_m = '0; mask_m = '0; ctrl_m = '0;
    for (int k = 0; k < NC; k++) ctr_m[k] = '0;
    for (int k = 0; k < NS; k++) spec_m[k] = '0;
    stat = 8'h5A;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 oe after reset", rd_oe, 1'b0);
    chk("R13 irq after reset", irq, 1'b0);
    for (int a = 0; a < 16; a++) do_read(4'(a), 0, '0, '0, got);

    // R6 / R1 basic writes and readback, R7 held select with changing data
    do_write(4'd1, 8'hFF, 0);
    do_write(4'd6, 8'h3C, 0);
    do_read(4'd6, 1, '0, '0, got);
    do_write(4'd6, 8'h96, 3);
    do_read(4'd6, 0, '0, '0, got);
    chk("R7 single write kept", got, 8'h96);

    // R8 read-only write -> error bit, register untouched
    do_write(4'd5, 8'h11, 0);
    do_write(4'd3, 8'h22, 1);
    do_read(4'd3, 0, '0, '0, got);
    chk("R8 counter untouched", got, 8'h00);
    do_read(4'd0, 0, '0, '0, got);
    chk("R8 error bit set", got, 8'h80);
    do_read(4'd0, 0, '0, '0, got);
    chk("R5 cleared after read", got, 8'h00);

    // R9 lock
    lock = 1'b1;
    do_write(4'd8, 8'h44, 0);
    do_read(4'd8, 0, '0, '0, got);
    chk("R9 locked write dropped", got, 8'h00);
    lock = 1'b0;
    do_write(4'd8, 8'h45, 0);
    do_read(4'd8, 2, '0, '0, got);
    chk("R9 unlocked write", got, 8'h45);

    // R10 irq from masked event
    do_write(4'd1, 8'h01, 0);
    pulse_evt(7'h02);
    chk("R10 unmasked event no irq", irq, 1'b0);
    pulse_evt(7'h01);
    chk("R10 masked event irq", irq, 1'b1);
    do_read(4'd0, 0, '0, '0, got);
    chk("R10 irq after clear", irq, 1'b0);

    // R11 collisions with clear-on-read
    pulse_evt(7'h04);
    do_read(4'd0, 0, 7'h10, '0, got);
    chk("R11 event read old", got, 8'h04);
    do_read(4'd0, 0, '0, '0, got);
    chk("R11 event kept", got, 8'h10);
    pulse_inc(3'b010, 5);
    do_read(4'd3, 1, '0, 3'b010, got);
    chk("R11 counter read old", got, 8'h05);
    do_read(4'd3, 0, '0, '0, got);
    chk("R11 counter kept", got, 8'h01);

    // R12 saturation
    pulse_inc(3'b001, 300);
    do_read(4'd2, 0, '0, '0, got);
    chk("R12 saturated", got, 8'hFF);

    // R4 long stretch
    do_read(4'd1, 6, '0, '0, got);

    // random mix
    for (int it = 0; it < 200; it++) begin
      r = int'($urandom_range(0, 5));
      case (r)
        0, 1: do_read(4'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                      '0, '0, got);
        2: begin
          lock = 1'($urandom_range(0, 1));
          do_write(4'($urandom_range(0, 15)), 8'($urandom), int'($urandom_range(0, 2)));
          lock = 1'b0;
        end
        3: begin pulse_evt(7'($urandom)); chk_irq(); end
        4: pulse_inc(3'($urandom), int'($urandom_range(1, 5)));
        default: stat = 8'($urandom);
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule